// File: doc/BRIEF.md
# Attribute Pixel Colour Stage

This block is the last per-pixel stage of a planar video controller. Every clock it receives one pixel's worth of context. In graphics mode that context is a 4-bit value gathered from the four bit planes. In text mode it is the current font dot, the character code and the character attribute byte. From this the block forms a 4-bit palette index and looks it up in a sixteen-entry table of 6-bit colours. The colour leaves on a registered output one clock later. Outside the active display area, a separately programmed border colour takes the place of the palette result.

A small write port loads the colour table and four control registers: mode, border colour, plane control and pan value. The mode register selects several things:
- graphics or text interpretation,
- a monochrome reduction of the index,
- 9-dot character cells with a line-drawing fill rule for the ninth column,
- whether attribute bit 7 means blinking or a bright background.

The block also outputs two bits of the current output colour, chosen by a select field, for diagnostic polling. It also outputs the horizontal pixel shift that the fetch logic must apply for the programmed pan value.

Top module: `attr_pixel_stage`

## Requirements
- R1: After reset `color_out` is 0, `blank_out` is 1, `stat_bits` is 0 and `pan_shift` is 0. All table entries and control registers are 0.
- R2: A write with `wr_en` high updates the target on the next rising edge. The write index selects the target:
  - index 0..15: the colour table entry, from `wr_data[5:0]`;
  - index 16: the mode register, with bit0 graphics, bit1 mono, bit2 nine-dot and bit3 blink-select;
  - index 17: the border colour, from `wr_data[5:0]`;
  - index 18: plane control, with bits[3:0] the plane enables and bits[5:4] the status select;
  - index 19: the pan value, from `wr_data[3:0]`.
- R3: `color_out` and `blank_out` reflect the inputs sampled at the previous rising edge (one clock of latency).
- R4: Index bit k reaches the colour table only when plane-enable bit k is set; otherwise it is 0.
- R5: In graphics mode (mode bit0 = 1) the raw index is `pix_planes`.
- R6: In text mode with blink-select clear, a set font dot selects `char_attr[3:0]` (foreground) and a clear dot selects `char_attr[7:4]` (background).
- R7: With blink-select set, the background is `{0, char_attr[6:4]}`. When `char_attr[7]` is set and `blink_phase` is low, the foreground is replaced by that background.
- R8: In text mode with nine-dot set and `col9` high, the effective dot is `font_dot8` for character codes 0xC0 to 0xDF and 0 for all other codes. With nine-dot clear, `col9` is ignored.
- R9: With mono set, raw index bits 1 and 2 are forced to 0 before plane masking.
- R10: When `active` is low, the output colour is the border colour.
- R11: `stat_bits` is taken from the current `color_out`, according to the status select:
  - 0 gives {bit2, bit0};
  - 1 gives {bit3, bit1};
  - 2 gives {bit5, bit4};
  - 3 gives 0.
- R12: `pan_shift` depends on the pan value v and the mode:
  - in text mode with nine-dot set, v = 0..7 gives v+1 and any other value gives 0;
  - otherwise, v = 0..7 gives v and any other value gives 0.
- R13: Writes to indices 20..31 change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 5 | Register write index |
| wr_data | input | 6 | Register write data |
| active | input | 1 | Pixel lies in the active display area |
| blank_in | input | 1 | Blanking flag, delayed alongside the colour |
| pix_planes | input | 4 | Plane bits for graphics mode |
| char_code | input | 8 | Character code for text mode |
| char_attr | input | 8 | Character attribute byte |
| font_dot | input | 1 | Font dot for columns 1..8 |
| font_dot8 | input | 1 | Eighth font dot of the current row |
| col9 | input | 1 | Current pixel is the ninth cell column |
| blink_phase | input | 1 | Blink phase, high = visible |
| color_out | output | 6 | Registered output colour |
| blank_out | output | 1 | Registered blanking flag |
| stat_bits | output | 2 | Two selected bits of `color_out` |
| pan_shift | output | 4 | Pixel shift for the pan value |

## Verification
The hardest situation to reach is when several settings overlap: a ninth-column pixel of a line-drawing code, in text mode, with blink-select, mono and a partial plane mask all in force at once. Random stimulus reaches it only rarely, because each condition depends on a separately written register. The stimulus therefore rewrites the control registers often with random values, and biases character codes towards the edges of the 0xC0..0xDF range. Directed passes then pin down each boundary code and each blink phase with a full plane mask.

// File: rtl/apc_pkg.sv
package apc_pkg;
  localparam int IDX_W   = 4;
  localparam int PAL_N   = 1 << IDX_W;
  localparam int COL_W   = 6;
  localparam int ADDR_W  = 5;
  localparam int PAN_W   = 4;
  localparam int CODE_W  = 8;
  localparam int ATTR_W  = 8;
  localparam int SEL_W   = 2;
  localparam int PAN_MAX = 8;

  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(PAL_N);
  localparam logic [ADDR_W-1:0] A_OVER  = ADDR_W'(PAL_N + 1);
  localparam logic [ADDR_W-1:0] A_PLANE = ADDR_W'(PAL_N + 2);
  localparam logic [ADDR_W-1:0] A_PAN   = ADDR_W'(PAL_N + 3);

  typedef struct packed {
    logic blink_sel;
    logic nine_dot;
    logic mono;
    logic graphics;
  } mode_t;

  typedef struct packed {
    logic [SEL_W-1:0] mux_sel;
    logic [IDX_W-1:0] plane_en;
  } plane_t;

  function automatic logic [PAN_W-1:0] pan_map(input logic [PAN_W-1:0] v,
                                               input logic text9);
    if (int'(v) < PAN_MAX) begin
      if (text9) return PAN_W'(int'(v) + 1);
      return v;
    end
    return '0;
  endfunction

  function automatic logic [1:0] stat_pick(input logic [COL_W-1:0] c,
                                           input logic [SEL_W-1:0] sel);
    case (sel)
      2'd0:    return {c[2], c[0]};
      2'd1:    return {c[3], c[1]};
      2'd2:    return {c[5], c[4]};
      default: return 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/apc_regs.sv
module apc_regs
  import apc_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_idx,
  input  logic [COL_W-1:0]              wr_data,
  output logic [PAL_N-1:0][COL_W-1:0]   pal,
  output mode_t                         mode,
  output logic [COL_W-1:0]              overscan,
  output plane_t                        plane,
  output logic [PAN_W-1:0]              pan
);
  logic stray_wr;
  assign stray_wr = wr_en && (wr_idx > A_PAN);

  for (genvar g = 0; g < PAL_N; g++) begin : g_pal
    logic hit;
    assign hit = wr_en && (wr_idx == ADDR_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)   pal[g] <= '0;
      else if (hit) pal[g] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode     <= '0;
      overscan <= '0;
      plane    <= '0;
      pan      <= '0;
    end else if (wr_en) begin
      case (wr_idx)
        A_MODE:  mode     <= mode_t'(wr_data[3:0]);
        A_OVER:  overscan <= wr_data;
        A_PLANE: plane    <= plane_t'(wr_data);
        A_PAN:   pan      <= wr_data[PAN_W-1:0];
        default: ;
      endcase
    end
  end

  // R13: indices above the pan register leave every register untouched
  a_r13_stray_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    stray_wr |=> ($stable(mode) && $stable(overscan) && $stable(plane) &&
                  $stable(pan) && $stable(pal)));

  // R2: a write to the border index lands on the next edge
  a_r2_border_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == A_OVER) |=> (overscan == $past(wr_data)));
endmodule

// File: rtl/apc_index.sv
module apc_index
  import apc_pkg::*;
#(
  parameter logic [CODE_W-1:0] LINE_LO   = 8'hC0,
  parameter logic [CODE_W-1:0] LINE_HI   = 8'hDF,
  parameter logic [IDX_W-1:0]  MONO_KEEP = 4'b1001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mode_t             mode,
  input  logic [IDX_W-1:0]  plane_en,
  input  logic [IDX_W-1:0]  pix_planes,
  input  logic [CODE_W-1:0] char_code,
  input  logic [ATTR_W-1:0] char_attr,
  input  logic              font_dot,
  input  logic              font_dot8,
  input  logic              col9,
  input  logic              blink_phase,
  output logic [IDX_W-1:0]  idx
);
  logic             in_line;
  logic             ninth_col;
  logic             dot_eff;
  logic             blink_off;
  logic [IDX_W-1:0] fg, bg, txt_idx, raw_idx, mono_mask;

  always_comb begin
    in_line   = (char_code >= LINE_LO) && (char_code <= LINE_HI);
    ninth_col = col9 && mode.nine_dot;
    dot_eff   = ninth_col ? (in_line && font_dot8) : font_dot;
    bg        = mode.blink_sel ? {1'b0, char_attr[6:4]} : char_attr[7:4];
    blink_off = mode.blink_sel && char_attr[7] && !blink_phase;
    fg        = blink_off ? bg : char_attr[3:0];
    txt_idx   = dot_eff ? fg : bg;
    raw_idx   = mode.graphics ? pix_planes : txt_idx;
    mono_mask = mode.mono ? MONO_KEEP : '1;
    idx       = raw_idx & mono_mask & plane_en;
  end

  // R4: disabled planes never reach the table
  a_r4_plane_mask: assert property (@(posedge clk) disable iff (!rst_n)
    ((idx & ~plane_en) == '0));

  // R9: mono keeps only index bits 0 and 3
  a_r9_mono_bits: assert property (@(posedge clk) disable iff (!rst_n)
    mode.mono |-> (idx[2:1] == 2'b00));

  // R8: ninth column of a non-line code shows background
  a_r8_ninth_bg: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode.graphics && ninth_col && !in_line) |->
      (idx == (bg & mono_mask & plane_en)));

  // R7: hidden blink phase shows background for every dot
  a_r7_blink_hide: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode.graphics && blink_off) |-> (idx == (bg & mono_mask & plane_en)));
endmodule

// File: rtl/apc_pan.sv
module apc_pan
  import apc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PAN_W-1:0] pan_val,
  input  logic             text9,
  output logic [PAN_W-1:0] shift
);
  assign shift = pan_map(pan_val, text9);

  // R12: shift never exceeds a full cell
  a_r12_pan_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(shift) <= PAN_MAX);

  // R12: outside 9-dot text the shift stays below a byte
  a_r12_pan_plain: assert property (@(posedge clk) disable iff (!rst_n)
    !text9 |-> (int'(shift) < PAN_MAX));
endmodule

// File: rtl/attr_pixel_stage.sv
module attr_pixel_stage
  import apc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [4:0]        wr_idx,
  input  logic [5:0]        wr_data,
  input  logic              active,
  input  logic              blank_in,
  input  logic [3:0]        pix_planes,
  input  logic [7:0]        char_code,
  input  logic [7:0]        char_attr,
  input  logic              font_dot,
  input  logic              font_dot8,
  input  logic              col9,
  input  logic              blink_phase,
  output logic [5:0]        color_out,
  output logic              blank_out,
  output logic [1:0]        stat_bits,
  output logic [3:0]        pan_shift
);
  logic [PAL_N-1:0][COL_W-1:0] pal;
  mode_t                       mode;
  logic [COL_W-1:0]            overscan;
  plane_t                      plane;
  logic [PAN_W-1:0]            pan;
  logic [IDX_W-1:0]            idx;
  logic [COL_W-1:0]            pix_col;
  logic [COL_W-1:0]            color_q;
  logic                        blank_q;
  logic                        text9;
  logic                        seen;

  apc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .pal(pal), .mode(mode), .overscan(overscan),
    .plane(plane), .pan(pan)
  );

  apc_index u_index (
    .clk(clk), .rst_n(rst_n), .mode(mode), .plane_en(plane.plane_en),
    .pix_planes(pix_planes), .char_code(char_code), .char_attr(char_attr),
    .font_dot(font_dot), .font_dot8(font_dot8), .col9(col9),
    .blink_phase(blink_phase), .idx(idx)
  );

  assign text9 = !mode.graphics && mode.nine_dot;

  apc_pan u_pan (
    .clk(clk), .rst_n(rst_n), .pan_val(pan), .text9(text9), .shift(pan_shift)
  );

  assign pix_col = active ? pal[idx] : overscan;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      color_q <= '0;
      blank_q <= 1'b1;
      seen    <= 1'b0;
    end else begin
      color_q <= pix_col;
      blank_q <= blank_in;
      seen    <= 1'b1;
    end
  end

  assign color_out = color_q;
  assign blank_out = blank_q;
  assign stat_bits = stat_pick(color_q, plane.mux_sel);

  // R3: blanking travels with one clock of delay
  a_r3_blank_delay: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (blank_out == $past(blank_in)));

  // R10: inactive pixels show the border colour
  a_r10_border: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !$past(active)) |-> (color_out == $past(overscan)));

  // R11: the unused select value exposes nothing
  a_r11_stat_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (plane.mux_sel == 2'd3) |-> (stat_bits == 2'b00));
endmodule

// File: tb/tb_attr_pixel_stage.sv
module tb_attr_pixel_stage;
  logic clk = 0;
  logic rst_n = 0;
  logic wr_en = 0;
  logic [4:0] wr_idx = 0;
  logic [5:0] wr_data = 0;
  logic active = 0, blank_in = 1;
  logic [3:0] pix_planes = 0;
  logic [7:0] char_code = 0, char_attr = 0;
  logic font_dot = 0, font_dot8 = 0, col9 = 0, blink_phase = 1;
  logic [5:0] color_out;
  logic blank_out;
  logic [1:0] stat_bits;
  logic [3:0] pan_shift;

  int total = 0, bad = 0;
  bit done = 0;

  logic [5:0] s_pal [16];
  logic [3:0] s_mode;
  logic [5:0] s_ov;
  logic [5:0] s_pl;
  logic [3:0] s_pan;

  always #4 clk = ~clk;

  attr_pixel_stage dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .active(active), .blank_in(blank_in), .pix_planes(pix_planes),
    .char_code(char_code), .char_attr(char_attr), .font_dot(font_dot),
    .font_dot8(font_dot8), .col9(col9), .blink_phase(blink_phase),
    .color_out(color_out), .blank_out(blank_out), .stat_bits(stat_bits),
    .pan_shift(pan_shift)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] ref_index();
    logic [3:0] fg, bg, ix;
    logic d;
    if (s_mode[0]) ix = pix_planes;
    else begin
      fg = char_attr[3:0];
      bg = s_mode[3] ? {1'b0, char_attr[6:4]} : char_attr[7:4];
      if (s_mode[3] && char_attr[7] && !blink_phase) fg = bg;
      if (col9 && s_mode[2])
        d = (char_code >= 8'hC0 && char_code <= 8'hDF) ? font_dot8 : 1'b0;
      else d = font_dot;
      ix = d ? fg : bg;
    end
    if (s_mode[1]) ix = {ix[3], 2'b00, ix[0]};
    return ix & s_pl[3:0];
  endfunction

  function automatic logic [5:0] ref_color();
    if (!active) return s_ov;
    return s_pal[ref_index()];
  endfunction

  function automatic logic [1:0] ref_stat(input logic [5:0] c);
    case (s_pl[5:4])
      2'd0: return {c[2], c[0]};
      2'd1: return {c[3], c[1]};
      2'd2: return {c[5], c[4]};
      default: return 2'b00;
    endcase
  endfunction

  function automatic int ref_pan();
    int v = int'(s_pan);
    if (v > 7) return 0;
    return (!s_mode[0] && s_mode[2]) ? v + 1 : v;
  endfunction

  task automatic wr(input int idx, input int d);
    wr_en = 1; wr_idx = 5'(idx); wr_data = 6'(d);
    @(negedge clk);
    wr_en = 0;
    if (idx < 16) s_pal[idx] = 6'(d);
    else if (idx == 16) s_mode = 4'(d);
    else if (idx == 17) s_ov = 6'(d);
    else if (idx == 18) s_pl = 6'(d);
    else if (idx == 19) s_pan = 4'(d);
  endtask

  task automatic pix(input string req);
    logic [5:0] ec;
    logic eb;
    ec = ref_color();
    eb = blank_in;
    @(negedge clk);
    chk(req, color_out, ec);
    chk({req, " blank"}, blank_out, eb);
    chk("R11 stat", stat_bits, ref_stat(ec));
  endtask

  task automatic text(input logic [7:0] code, input logic [7:0] attr,
                      input logic d, input logic d8, input logic c9,
                      input logic ph, input string req);
    active = 1; char_code = code; char_attr = attr; font_dot = d;
    font_dot8 = d8; col9 = c9; blink_phase = ph;
    pix(req);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int seed = 32'h5eed;
    void'($urandom(seed));
    for (int i = 0; i < 16; i++) s_pal[i] = 0;
    s_mode = 0; s_ov = 0; s_pl = 0; s_pan = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chk("R1 color", color_out, 0);
    chk("R1 blank", blank_out, 1);
    chk("R1 stat", stat_bits, 0);
    chk("R1 pan", pan_shift, 0);

    // R2: program table and controls
    for (int i = 0; i < 16; i++) wr(i, (i * 37 + 11) & 63);
    wr(17, 6'h2a);
    wr(18, 6'h0f);
    wr(16, 4'b0001);
    chk("R2 pan reg", pan_shift, 0);

    // R5 / R3: graphics mode, several patterns, blank alternating
    for (int p = 0; p < 16; p++) begin
      active = 1; pix_planes = 4'(p); blank_in = p[0];
      pix("R5 graphics");
    end
    // R3: latency – a one-cycle pulse shows up exactly one cycle later
    pix_planes = 4'd3; blank_in = 0; pix("R3 hold");
    pix_planes = 4'd9; blank_in = 1; pix("R3 step");
    // R4: partial plane mask
    wr(18, 6'b00_0101);
    pix_planes = 4'hF; pix("R4 mask");
    pix_planes = 4'hA; pix("R4 mask zero");
    // R10: border colour
    active = 0; pix("R10 border");
    active = 1;

    // R6: text, no blink
    wr(18, 6'h0f);
    wr(16, 4'b0000);
    text(8'h41, 8'h5c, 1, 0, 0, 1, "R6 fg");
    text(8'h41, 8'h5c, 0, 1, 0, 1, "R6 bg");
    text(8'h41, 8'hd3, 0, 0, 0, 0, "R6 bright bg");
    // R7: blink select
    wr(16, 4'b1000);
    text(8'h41, 8'hd3, 1, 0, 0, 1, "R7 blink visible");
    text(8'h41, 8'hd3, 1, 0, 0, 0, "R7 blink hidden");
    text(8'h41, 8'hd3, 0, 0, 0, 1, "R7 bg three bits");
    text(8'h41, 8'h53, 1, 0, 0, 0, "R7 no blink attr");
    // R8: ninth column
    wr(16, 4'b0100);
    text(8'hC0, 8'h1e, 0, 1, 1, 1, "R8 low edge copy");
    text(8'hDF, 8'h1e, 0, 1, 1, 1, "R8 high edge copy");
    text(8'hBF, 8'h1e, 1, 1, 1, 1, "R8 below range");
    text(8'hE0, 8'h1e, 1, 1, 1, 1, "R8 above range");
    text(8'hC5, 8'h1e, 1, 0, 1, 1, "R8 copy zero");
    wr(16, 4'b0000);
    text(8'hBF, 8'h1e, 1, 0, 1, 1, "R8 nine off col9 ignored");
    // R9: mono
    wr(16, 4'b0011);
    pix_planes = 4'hF; pix("R9 mono");
    pix_planes = 4'h6; pix("R9 mono zero");
    // R11: every select value
    for (int s = 0; s < 4; s++) begin
      wr(18, (s << 4) | 6'h0f);
      pix_planes = 4'hB; wr(16, 4'b0001);
      pix("R11 select");
    end
    // R12: pan map in both modes
    for (int m = 0; m < 2; m++) begin
      wr(16, m ? 4'b0100 : 4'b0001);
      for (int v = 0; v < 16; v++) begin
        wr(19, v);
        chk("R12 pan", pan_shift, ref_pan());
      end
    end
    // R13: stray indices
    wr(19, 5); wr(16, 4'b0001); wr(18, 6'h0f);
    for (int k = 20; k < 32; k++) begin
      wr(k, 6'h3f);
      chk("R13 pan kept", pan_shift, ref_pan());
      pix_planes = 4'(k); active = 1; pix("R13 color kept");
      active = 0; pix("R13 border kept");
    end

    // Random phase: R5..R10 mixed
    for (int n = 0; n < 4000; n++) begin
      string tag;
      if (($urandom % 8) == 0) wr($urandom % 32, $urandom % 64);
      active = ($urandom % 6) != 0;
      blank_in = $urandom % 2;
      pix_planes = 4'($urandom);
      case ($urandom % 4)
        0: char_code = 8'hC0 + 8'($urandom % 32);
        1: char_code = ($urandom % 2) ? 8'hBF : 8'hE0;
        default: char_code = 8'($urandom);
      endcase
      char_attr = 8'($urandom);
      font_dot = $urandom % 2; font_dot8 = $urandom % 2;
      col9 = $urandom % 2; blink_phase = $urandom % 2;
      if (!active) tag = "R10 rand";
      else if (s_mode[0]) tag = "R5 rand";
      else if (col9 && s_mode[2]) tag = "R8 rand";
      else if (s_mode[3]) tag = "R7 rand";
      else tag = "R6 rand";
      pix(tag);
      chk("R12 rand", pan_shift, ref_pan());
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule